// File: doc/BRIEF.md
# Two-Stage Elastic Pipeline Buffer

This block is one stage of a latency-insensitive pipeline. It sits on a valid/ready channel and adds registers in both directions, so that a long chain of such stages can be built without long timing paths. Tokens that enter on the upstream side leave on the downstream side in the same order. None is lost and none is duplicated. When downstream accepts every cycle, the stage passes one token per cycle.

Two kinds of buffer make up the stage. The first is a pipeline register holding a data word and a valid flag. It loads whenever it is empty or its consumer takes its token, and it cuts the forward data/valid path. The second sits downstream of the first. It drives its upstream ready from a flip-flop. When downstream withdraws ready while a token is in flight, that token goes into a one-entry side register. A 2:1 mux then presents the side token ahead of any newer one. This stage cuts the backward ready path.

Top module: `elastic_pipe_buffer`

## Requirements
- R1: While reset is held and right after it is released, the block holds no token: m_valid is 0 and s_ready is 1.
- R2: A token moves when valid and ready are both 1 on the same clock edge. The sequence of m_data words accepted downstream equals the sequence of s_data words accepted upstream, with nothing lost, duplicated or reordered.
- R3: While m_valid is 1 and m_ready is 0, m_valid stays 1 on the next cycle and m_data does not change.
- R4: With s_valid and m_ready held at 1, s_ready stays 1 every cycle. m_valid is 1 from the cycle after the first acceptance onward, so one token is delivered per cycle. A token accepted on one edge is offered downstream immediately after that edge.
- R5: m_valid and m_data come only from flip-flops. Changing m_ready or s_valid within a cycle does not change them in that cycle.
- R6: s_ready comes only from flip-flops. Changing m_ready or s_valid within a cycle does not change it in that cycle.
- R7: Starting empty with m_ready held at 0, the block accepts exactly two tokens on consecutive edges and then drives s_ready to 0. While it holds a single token and downstream is stalled, s_ready stays 1.
- R8: A token diverted into the side register is delivered downstream before any token that arrived after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Upstream token present |
| s_data | input | DATA_W | Upstream token payload |
| s_ready | output | 1 | Block can take an upstream token |
| m_valid | output | 1 | Downstream token present |
| m_data | output | DATA_W | Downstream token payload |
| m_ready | input | 1 | Downstream takes the token |

## Verification
The first pattern is a continuous stream with both sides always willing. It shows whether the stage really delivers one token per cycle or adds bubbles. The second is a stall from empty. It shows the two-token capacity, that the empty data register still fills while downstream waits, and that the side token leaves first once ready returns. Mid-cycle toggles of m_ready and s_valid show whether any output follows an input combinationally. Long runs of random s_valid and m_ready, scored against a queue of accepted words, catch lost, duplicated or reordered tokens and any change to a held output.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

    parameter int unsigned EB_DATA_W_DEF = 16;

    // Source chosen by the control stage output mux
    typedef enum logic {
        SRC_PASS = 1'b0,
        SRC_SIDE = 1'b1
    } eb_src_e;

endpackage

// File: rtl/eb_data_stage.sv
module eb_data_stage #(
    parameter int unsigned W = elastic_pkg::EB_DATA_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } dstate_t;

    dstate_t st_d, st_q;
    logic    load_en;

    always_comb begin
        st_d    = st_q;
        load_en = out_ready | ~st_q.vld;
        if (load_en) begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.dat = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = load_en;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

    // R3
    dhold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/eb_ctrl_stage.sv
module eb_ctrl_stage #(
    parameter int unsigned W = elastic_pkg::EB_DATA_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    import elastic_pkg::*;

    typedef struct packed {
        logic         full;
        logic [W-1:0] dat;
    } cstate_t;

    cstate_t st_d, st_q;
    eb_src_e src_sel;

    always_comb begin
        st_d = st_q;
        if (st_q.full) begin
            // side token has priority; it leaves when downstream takes it
            if (out_ready) begin
                st_d.full = 1'b0;
            end
        end else if (in_valid && !out_ready) begin
            // in-flight token accepted upstream but refused downstream
            st_d.full = 1'b1;
            st_d.dat  = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_sel   = st_q.full ? SRC_SIDE : SRC_PASS;
    assign in_ready  = ~st_q.full;
    assign out_valid = (src_sel == SRC_SIDE) ? 1'b1 : in_valid;
    assign out_data  = (src_sel == SRC_SIDE) ? st_q.dat : in_data;

    // R7
    side_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.full) |-> $past(in_valid && !out_ready));

    // R8
    side_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && out_ready) |=> !st_q.full);

    // R8
    side_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !out_ready) |=> (out_valid && out_data == $past(st_q.dat)));

endmodule

// File: rtl/elastic_pipe_buffer.sv
module elastic_pipe_buffer #(
    parameter int unsigned DATA_W = elastic_pkg::EB_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_ready,
    output logic              m_valid,
    output logic [DATA_W-1:0] m_data,
    input  logic              m_ready
);

    logic              mid_valid;
    logic [DATA_W-1:0] mid_data;
    logic              mid_ready;

    eb_data_stage #(.W(DATA_W)) u_dstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_valid),
        .in_data   (s_data),
        .in_ready  (s_ready),
        .out_valid (mid_valid),
        .out_data  (mid_data),
        .out_ready (mid_ready)
    );

    eb_ctrl_stage #(.W(DATA_W)) u_cstage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (mid_valid),
        .in_data   (mid_data),
        .in_ready  (mid_ready),
        .out_valid (m_valid),
        .out_data  (m_data),
        .out_ready (m_ready)
    );

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !s_ready) |=> !s_ready);

endmodule

// File: tb/elastic_pipe_buffer_bench.sv
`timescale 1ns/100ps
module elastic_pipe_buffer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         s_valid = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         s_ready;
    logic         m_valid;
    logic [W-1:0] m_data;
    logic         m_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int sent   = 0;
    int recv   = 0;
    logic [W-1:0] next_data = 16'h0100;
    logic [W-1:0] expq[$];
    logic         prev_hold = 1'b0;
    logic [W-1:0] prev_data = '0;

    always #2 clk = ~clk;

    elastic_pipe_buffer #(.DATA_W(W)) u_elastic_pipe_buffer (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard: values at negedge equal the values at the next posedge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold) begin
                chk(m_valid == 1'b1, "R3 valid held", m_valid, 1);
                chk(m_data == prev_data, "R3 data held", m_data, prev_data);
            end
            if (m_valid && m_ready) begin
                if (expq.size() == 0) begin
                    chk(0, "R2 unexpected token", m_data, 0);
                end else begin
                    chk(m_data == expq[0], "R2 order", m_data, expq[0]);
                    void'(expq.pop_front());
                end
                recv++;
            end
            if (s_valid && s_ready) begin
                expq.push_back(s_data);
                next_data = next_data + 16'd1;
                sent++;
            end
            prev_hold = m_valid && !m_ready;
            prev_data = m_data;
        end else begin
            prev_hold = 1'b0;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(0, "R2 watchdog", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic drive(input logic v, input logic r);
        @(posedge clk);
        #1;
        s_valid = v;
        m_ready = r;
        s_data  = next_data;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
        expq.delete();
        sent = 0; recv = 0;
        repeat (2) @(posedge clk);
        #0.5;
        chk(m_valid == 1'b0, "R1 m_valid in reset", m_valid, 0);
        chk(s_ready == 1'b1, "R1 s_ready in reset", s_ready, 1);
        #0.5;
        rst_n = 1'b1;
    endtask

    task automatic test_reset();
        do_reset();
        @(negedge clk);
        chk(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
        chk(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
    endtask

    task automatic test_stream();
        do_reset();
        for (int i = 0; i < 24; i++) begin
            drive(1'b1, 1'b1);
            @(negedge clk);
            chk(s_ready == 1'b1, "R4 s_ready stream", s_ready, 1);
            if (i > 0) chk(m_valid == 1'b1, "R4 m_valid stream", m_valid, 1);
            else       chk(m_valid == 1'b0, "R4 first cycle empty", m_valid, 0);
        end
        drive(1'b0, 1'b1);
        repeat (4) drive(1'b0, 1'b1);
        chk(recv == 24, "R4 delivered count", recv, 24);
        chk(expq.size() == 0, "R2 stream drained", expq.size(), 0);
    endtask

    task automatic test_stall();
        logic [W-1:0] first;
        do_reset();
        first = next_data;
        drive(1'b1, 1'b0);
        @(negedge clk);
        chk(s_ready == 1'b1, "R7 empty accepts", s_ready, 1);
        chk(m_valid == 1'b0, "R7 empty no output", m_valid, 0);
        drive(1'b1, 1'b0);
        @(negedge clk);
        chk(s_ready == 1'b1, "R7 one token still accepts", s_ready, 1);
        chk(m_valid == 1'b1 && m_data == first, "R7 first offered", m_data, first);
        drive(1'b1, 1'b0);
        @(negedge clk);
        chk(s_ready == 1'b0, "R7 full after two", s_ready, 0);
        chk(m_data == first, "R8 side token on output", m_data, first);
        repeat (3) begin
            drive(1'b1, 1'b0);
            @(negedge clk);
            chk(s_ready == 1'b0, "R7 stays full", s_ready, 0);
        end
        chk(sent == 2, "R7 two accepted", sent, 2);
        drive(1'b1, 1'b1);
        @(negedge clk);
        chk(m_data == first, "R8 side token leaves first", m_data, first);
        repeat (3) drive(1'b1, 1'b1);
        repeat (5) drive(1'b0, 1'b1);
        chk(expq.size() == 0, "R2 stall drained", expq.size(), 0);
    endtask

    task automatic test_comb();
        logic         v0, r0;
        logic [W-1:0] d0;
        do_reset();
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
        #0.2;
        v0 = m_valid; r0 = s_ready; d0 = m_data;
        m_ready = 1'b1; s_valid = 1'b1;
        #0.3;
        chk(m_valid == v0 && m_data == d0, "R5 output vs inputs", m_valid, v0);
        chk(s_ready == r0, "R6 s_ready vs inputs", s_ready, r0);
        m_ready = 1'b0; s_valid = 1'b0;
        #0.3;
        chk(m_valid == v0 && m_data == d0, "R5 output restored", m_data, d0);
        chk(s_ready == r0, "R6 s_ready restored", s_ready, r0);
        repeat (6) drive(1'b0, 1'b1);
        chk(expq.size() == 0, "R2 comb drained", expq.size(), 0);
    endtask

    task automatic test_random(input int n, input int vpct, input int rpct);
        do_reset();
        for (int i = 0; i < n; i++) begin
            drive(($urandom % 100) < vpct, ($urandom % 100) < rpct);
        end
        repeat (6) drive(1'b0, 1'b1);
        chk(expq.size() == 0, "R2 random drained", expq.size(), 0);
        chk(sent == recv, "R2 random counts", recv, sent);
    endtask

    initial begin
        test_reset();
        test_stream();
        test_stall();
        test_comb();
        test_random(3000, 60, 60);
        test_random(3000, 90, 30);
        test_random(3000, 30, 90);
        summary();
        $finish;
    end

endmodule